// File: doc/BRIEF.md
# Shared-Product Symmetric FIR Filter Bank

This block is the accumulate-and-delay half of a bank of eight 16-tap filters in transposed form. Upstream logic forms eight signed 8-bit products per input slot, one for each distinct coefficient magnitude of a symmetric filter. Each slot belongs to one channel, and an internal rotating channel counter chooses which one. The counter value is offered on `slot_ch`, so the upstream multiplexer knows which channel's sample to multiply next.

On every slot, each product drives two mirrored taps of the selected channel's delay line: tap k and tap 15−k. Each of those taps has its own sign bit. A set sign bit negates the product before it is added. The selected channel's sixteen 12-bit registers then shift by one stage with saturating adds. The new head value is presented one cycle later with a valid pulse and the channel number. Every channel therefore advances once per eight slots.

Top module: `tdm_sym_fir`

## Requirements
- R1: A synchronous reset clears all 8×16 delay registers, sets `slot_ch` to 0 and holds `out_valid` low. The first output for each channel after reset reflects only products delivered after reset.
- R2: `slot_ch` advances by one, wrapping from 7 to 0, on each clock edge with `in_valid` high. It holds its value when `in_valid` is low.
- R3: `out_valid` is high exactly in the cycle after an edge with `in_valid` high. `out_ch` then equals the `slot_ch` value of that slot.
- R4: Channel c's n-th output is the sum over k = 0..15 of ±P(n−k)[j]. P(m) is the product vector of channel c's m-th slot. Product j = min(k, 15−k) occupies `prod[8j+7:8j]`.
- R5: Bit c·16+k of `sign_cfg` set to 1 negates tap k of channel c. Set to 0, the product is added unchanged.
- R6: Results saturate at +2047 and −2048 rather than wrapping. A sum of exactly −2048 is represented without clamping.
- R7: A slot changes only the selected channel's delay line. The other channels' future outputs are unaffected.
- R8: A cycle with `in_valid` low changes no delay register and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Slot strobe: products present for channel `slot_ch` |
| prod | input | 64 | Eight signed 8-bit products, index j at bits 8j+7:8j |
| sign_cfg | input | 128 | Per-channel tap sign bits, bit c·16+k for tap k of channel c |
| slot_ch | output | 3 | Channel that owns the current slot |
| out_valid | output | 1 | Output strobe |
| out_ch | output | 3 | Channel tag of the output |
| out_data | output | 12 | Signed filtered output of the tagged channel |

## Verification
A slot driven before edge t produces its output in the cycle after t, behind one register. The bench drives on the falling edge and checks `out_valid`, `out_ch` and `out_data` on the next falling edge. `slot_ch` is due in that same sample and is compared against a counter the bench keeps itself. Expected outputs come from a direct-form convolution over a per-channel history of product vectors, with clamping, computed at the moment the slot is driven. Idle cycles are interleaved so that holding and the absence of a strobe are both checked at the same sampling point.

// File: rtl/tdm_sym_fir.sv
module tdm_sym_fir #(
  parameter int NCH  = 8,
  parameter int TAPS = 16,
  parameter int PW   = 8,
  parameter int AW   = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [TAPS/2*PW-1:0]   prod,
  input  logic [NCH*TAPS-1:0]    sign_cfg,
  output logic [$clog2(NCH)-1:0] slot_ch,
  output logic                   out_valid,
  output logic [$clog2(NCH)-1:0] out_ch,
  output logic signed [AW-1:0]   out_data
);
  localparam int NPROD = TAPS / 2;
  localparam int CW    = $clog2(NCH);
  localparam logic signed [AW-1:0] MAXV = {1'b0, {(AW-1){1'b1}}};
  localparam logic signed [AW-1:0] MINV = {1'b1, {(AW-1){1'b0}}};

  logic signed [AW-1:0] dl [NCH][TAPS];
  logic signed [AW-1:0] term [TAPS];
  logic [TAPS-1:0] sgn;

  assign sgn = sign_cfg[slot_ch*TAPS +: TAPS];

  function automatic logic signed [AW-1:0] sat_add(input logic signed [AW-1:0] a,
                                                    input logic signed [AW-1:0] b);
    logic signed [AW:0] s;
    s = {a[AW-1], a} + {b[AW-1], b};
    if (s[AW] != s[AW-1]) return s[AW] ? MINV : MAXV;
    return s[AW-1:0];
  endfunction

  always_comb begin
    for (int k = 0; k < TAPS; k++) begin
      int j;
      logic signed [PW-1:0] p;
      logic signed [AW-1:0] ext;
      j = (k < NPROD) ? k : TAPS - 1 - k;
      p = prod[j*PW +: PW];
      ext = {{(AW-PW){p[PW-1]}}, p};
      term[k] = sgn[k] ? -ext : ext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++)
        for (int k = 0; k < TAPS; k++)
          dl[c][k] <= '0;
      slot_ch   <= '0;
      out_valid <= 1'b0;
      out_ch    <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        for (int k = 0; k < TAPS - 1; k++)
          dl[slot_ch][k] <= sat_add(dl[slot_ch][k+1], term[k]);
        dl[slot_ch][TAPS-1] <= term[TAPS-1];
        out_data <= sat_add(dl[slot_ch][1], term[0]);
        out_ch   <= slot_ch;
        slot_ch  <= (slot_ch == CW'(NCH - 1)) ? '0 : slot_ch + 1'b1;
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !out_valid && slot_ch == '0); // R1
  AST_SEL_STEP: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> slot_ch == (($past(slot_ch) == CW'(NCH - 1)) ? '0 : $past(slot_ch) + 1'b1)); // R2
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(slot_ch)); // R2
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R3
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R8
  AST_TAG_MATCH: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_ch == $past(slot_ch)); // R3
endmodule

// File: tb/tdm_sym_fir_tb.sv
module tdm_sym_fir_tb;
  logic clk = 0, rst = 1, in_valid = 0;
  logic [63:0] prod = '0;
  logic [127:0] sign_cfg = '0;
  logic [2:0] slot_ch, out_ch;
  logic out_valid;
  logic signed [11:0] out_data;

  int errors = 0, checks = 0, mcnt = 0;
  int hist [8][16][8];

  always #10 clk = ~clk;

  tdm_sym_fir u_dut (.clk, .rst, .in_valid, .prod, .sign_cfg, .slot_ch,
                     .out_valid, .out_ch, .out_data);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int conv(int ch);
    int s = 0;
    for (int k = 0; k < 16; k++) begin
      int j = (k < 8) ? k : 15 - k;
      s += sign_cfg[ch*16+k] ? -hist[ch][k][j] : hist[ch][k][j];
    end
    if (s > 2047) s = 2047;
    if (s < -2048) s = -2048;
    return s;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    mcnt = 0;
    for (int c = 0; c < 8; c++)
      for (int k = 0; k < 16; k++)
        for (int j = 0; j < 8; j++) hist[c][k][j] = 0;
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 slot_ch after reset", slot_ch, 0);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic slot(bit v, int p [8], string req);
    int ch = mcnt, e = 0;
    in_valid = v;
    for (int j = 0; j < 8; j++) prod[j*8 +: 8] = 8'(p[j]);
    if (v) begin
      for (int k = 15; k > 0; k--)
        for (int j = 0; j < 8; j++) hist[ch][k][j] = hist[ch][k-1][j];
      for (int j = 0; j < 8; j++) hist[ch][0][j] = p[j];
      e = conv(ch);
      mcnt = (mcnt + 1) % 8;
    end
    @(negedge clk);
    in_valid = 0;
    chk(v ? "R3 out_valid" : "R8 no strobe when idle", out_valid, int'(v));
    chk("R2 slot_ch", slot_ch, mcnt);
    if (v) begin
      chk("R3 out_ch", out_ch, ch);
      chk(req, out_data, e);
    end
  endtask

  initial begin
    int p [8];
    int z [8];
    void'($urandom(32'd4177));
    for (int j = 0; j < 8; j++) z[j] = 0;
    do_reset();

    // R4/R5: random signs, random products, random idle gaps
    for (int i = 0; i < 4; i++) sign_cfg[i*32 +: 32] = $urandom;
    for (int n = 0; n < 600; n++) begin
      bit v = ($urandom % 5) != 0;
      for (int j = 0; j < 8; j++) p[j] = int'($urandom % 256) - 128;
      slot(v, p, "R4 convolution/R5 signs");
    end

    // R1: reset mid-stream, first outputs carry only new products
    do_reset();
    for (int j = 0; j < 8; j++) p[j] = j + 1;
    for (int n = 0; n < 8; n++) slot(1, p, "R1 fresh after reset");

    // R6: positive saturation, all taps negated on -128
    do_reset();
    sign_cfg = '1;
    for (int j = 0; j < 8; j++) p[j] = -128;
    for (int n = 0; n < 160; n++) slot(1, p, "R6 clamp at +2047");
    chk("R6 final positive clamp", out_data, 2047);

    // R6: exact -2048, no clamping
    do_reset();
    sign_cfg = '0;
    for (int n = 0; n < 160; n++) slot(1, p, "R6 exact -2048");
    chk("R6 final negative limit", out_data, -2048);
    for (int j = 0; j < 8; j++) p[j] = 127;
    for (int n = 0; n < 160; n++) slot(1, p, "R6 large positive sum");
    chk("R6 final 2032", out_data, 2032);

    // R7: only channel 0 receives products; others must stay zero
    do_reset();
    for (int i = 0; i < 4; i++) sign_cfg[i*32 +: 32] = $urandom;
    for (int n = 0; n < 200; n++) begin
      for (int j = 0; j < 8; j++) p[j] = int'($urandom % 256) - 128;
      slot(1, (mcnt == 0) ? p : z, "R7 channel isolation");
      if ($urandom % 3 == 0) slot(0, z, "R8 idle");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule